// File: doc/BRIEF.md
# Power-On Reset and Strap Capture Sequencer

This block orders the resets of a host bridge. While power-good is low it holds the processor and the PCI bus in reset and raises an address-hold output, which makes the processor float its address pins. After power-good rises it waits a fixed interval of about one millisecond. It then reads three strap pins that share the top host address lines and stores them inverted as a two-bit secondary cache size code and an SRAM-type bit. One clock later it releases all three outputs together.

After start-up, software can restart the processor through a one-byte reset control register in I/O space. A rising edge of its restart bit starts either a hard reset or a soft reset, depending on its enable bit. A hard reset is the same long CPU and PCI reset, but address-hold stays low. A soft reset is a short INIT pulse. When the processor reports a shutdown cycle, the block first asks an external PCI master to broadcast a shutdown special cycle. When that master acknowledges, the block pulses INIT.

The controller has six states:
- `ST_POR_WAIT`: power-on wait. Asynchronous entry when power-good falls.
- `ST_POR_DONE`: the straps have just been captured.
- `ST_RUN`: normal operation.
- `ST_HARD`: hard reset.
- `ST_SD_REQ`: waiting for the PCI master to acknowledge the shutdown broadcast.
- `ST_INIT`: INIT pulse.

Its transitions are:
- POR_WAIT→POR_DONE when the interval timer reaches zero. The straps are captured on this edge.
- POR_DONE→RUN unconditionally.
- RUN→HARD on a hard request.
- RUN→INIT on a soft request.
- RUN→SD_REQ on a shutdown cycle.
- HARD→RUN when the timer reaches zero.
- SD_REQ→INIT on acknowledge.
- INIT→RUN when the timer reaches zero.

Top module: `rst_strap_seq`

## Requirements
- R1: While `pwr_good` is low, the outputs are as follows: `cpu_rst`, `pci_rst` and `addr_hold` are 1. `cpu_init` and `sd_req` are 0. The strap outputs are 0. The control register is cleared.
- R2: The straps are sampled on the HOLD_CYC-th rising clock edge with `pwr_good` high, counting the first such edge as 1. HOLD_CYC equals CLK_KHZ × HOLD_MS. Address values on other edges have no effect.
- R3: `cache_size` is the inverse of `host_addr_hi[2:1]` (address bits 31:30). The codes are: strap 11 → 00, no secondary cache. Strap 10 → 01, reserved. Strap 01 → 10, 256 KB. Strap 00 → 11, 512 KB.
- R4: `sram_type` is the inverse of `host_addr_hi[0]` (address bit 29).
- R5: `cpu_rst`, `pci_rst` and `addr_hold` all fall on the clock edge after the strap sampling edge.
- R6: The control register is decoded at I/O address 0x0CF9. A strobe on `io_wr` stores all 8 bits of `io_wdata`. While `io_rd` is high and the address matches, `io_rdata` shows the stored byte; otherwise it is 0. Bit 1 is the hard-reset enable and bit 2 is the restart bit.
- R7: In RUN, a write that takes bit 2 from 0 to 1 with bit 1 = 1 starts a hard reset. `cpu_rst` and `pci_rst` are high for exactly HOLD_CYC cycles, starting after that edge. `addr_hold` and `cpu_init` stay 0 throughout.
- R8: In RUN, a write that takes bit 2 from 0 to 1 with bit 1 = 0 starts a soft reset. `cpu_init` is high for exactly INIT_CYC cycles (at least 2), starting after that edge. The other resets are unchanged.
- R9: A write that leaves bit 2 at 1, or that clears it, starts no reset.
- R10: In RUN, `shutdown_cyc` raises `sd_req` from the next cycle. `sd_req` stays high until an edge where `sd_ack` is high. After that edge, `sd_req` is 0 and `cpu_init` is high for INIT_CYC cycles.
- R11: Reset requests and shutdown cycles that arrive outside RUN are dropped. A register write made then is still stored.
- R12: When a restart write and `shutdown_cyc` arrive on the same edge, the write wins and the shutdown is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| pwr_good | input | 1 | Power good; low level is asynchronous reset |
| host_addr_hi | input | 3 | Host address bits 31:29, carrying the straps |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | I/O read enable |
| io_addr | input | IO_AW | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| shutdown_cyc | input | 1 | Processor shutdown cycle detected |
| sd_ack | input | 1 | PCI master has issued the shutdown broadcast |
| sd_req | output | 1 | Request for a shutdown special cycle on PCI |
| cpu_rst | output | 1 | Processor reset |
| pci_rst | output | 1 | PCI bus reset |
| addr_hold | output | 1 | Address hold to the processor |
| cpu_init | output | 1 | Processor INIT |
| cache_size | output | 2 | Inverted straps 31:30, cache size code |
| sram_type | output | 1 | Inverted strap 29 |

## Verification
Start-up is tried with each of the eight strap combinations held steady, which separates the four cache-size codes and both SRAM-type values. A further run changes the address every cycle, which exposes a sample taken one edge early or late. Restart writes are given in three forms: with and without the enable bit, with the restart bit already set, and during a reset already in progress. Together these separate hard from soft resets and a real rising edge from a level. Shutdowns are tried with a delayed acknowledge, an immediate acknowledge, and one that collides with a restart write, which shows the handshake ordering and the request priority.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT,
        ST_POR_DONE,
        ST_RUN,
        ST_HARD,
        ST_SD_REQ,
        ST_INIT
    } rsq_state_e;

    localparam int RSQ_HARD_EN_BIT = 1;
    localparam int RSQ_RESTART_BIT = 2;
    localparam int RSQ_DATA_W      = 8;

endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
    parameter int              W       = 16,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rsq_ctrl_reg.sv
module rsq_ctrl_reg
    import rsq_pkg::*;
#(
    parameter int              AW   = 16,
    parameter logic [AW-1:0]   ADDR = 16'h0CF9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [AW-1:0]         io_addr,
    input  logic [RSQ_DATA_W-1:0] io_wdata,
    output logic [RSQ_DATA_W-1:0] io_rdata,
    output logic                  req_hard,
    output logic                  req_soft
);

    logic [RSQ_DATA_W-1:0] ctrl_q;
    logic                  hit;
    logic                  wr_hit;
    logic                  restart_rise;

    assign hit          = (io_addr == ADDR);
    assign wr_hit       = io_wr && hit;
    assign restart_rise = wr_hit && io_wdata[RSQ_RESTART_BIT] && !ctrl_q[RSQ_RESTART_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit) begin
            ctrl_q <= io_wdata;
        end
    end

    always_comb begin
        req_hard = restart_rise && io_wdata[RSQ_HARD_EN_BIT];
        req_soft = restart_rise && !io_wdata[RSQ_HARD_EN_BIT];
        io_rdata = (io_rd && hit) ? ctrl_q : '0;
    end

endmodule

// File: rtl/rsq_strap_latch.sv
module rsq_strap_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [N-1:0] strap_in,
    output logic [N-1:0] strap_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strap_q[i] <= 1'b0;
            end else if (capture) begin
                strap_q[i] <= ~strap_in[i];
            end
        end
    end

endmodule

// File: rtl/rst_strap_seq.sv
module rst_strap_seq
    import rsq_pkg::*;
#(
    parameter int                 CLK_KHZ   = 50000,
    parameter int                 HOLD_MS   = 1,
    parameter int                 INIT_CYC  = 2,
    parameter int                 IO_AW     = 16,
    parameter logic [IO_AW-1:0]   CTRL_ADDR = 16'h0CF9
) (
    input  logic             clk,
    input  logic             pwr_good,
    input  logic [2:0]       host_addr_hi,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic             shutdown_cyc,
    input  logic             sd_ack,
    output logic             sd_req,
    output logic             cpu_rst,
    output logic             pci_rst,
    output logic             addr_hold,
    output logic             cpu_init,
    output logic [1:0]       cache_size,
    output logic             sram_type
);

    localparam int           HOLD_CYC = CLK_KHZ * HOLD_MS;
    localparam int           TW       = $clog2(HOLD_CYC + 1);
    localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] INIT_LD = TW'(INIT_CYC - 1);

    rsq_state_e    state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          strap_en;
    logic          req_hard;
    logic          req_soft;
    logic [2:0]    strap_q;

    rsq_timer #(
        .W       (TW),
        .RST_VAL (HOLD_LD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (pwr_good),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rsq_ctrl_reg #(
        .AW   (IO_AW),
        .ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (pwr_good),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .req_hard (req_hard),
        .req_soft (req_soft)
    );

    rsq_strap_latch #(
        .N (3)
    ) u_straps (
        .clk      (clk),
        .rst_n    (pwr_good),
        .capture  (strap_en),
        .strap_in (host_addr_hi),
        .strap_q  (strap_q)
    );

    assign cache_size = strap_q[2:1];
    assign sram_type  = strap_q[0];

    // State register
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state_q <= ST_POR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, timer loads and strap capture
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = HOLD_LD;
        strap_en = 1'b0;
        unique case (state_q)
            ST_POR_WAIT: begin
                if (tmr_zero) begin
                    strap_en = 1'b1;
                    state_d  = ST_POR_DONE;
                end
            end
            ST_POR_DONE: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (req_hard) begin
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                    state_d  = ST_HARD;
                end else if (req_soft) begin
                    tmr_load = 1'b1;
                    tmr_val  = INIT_LD;
                    state_d  = ST_INIT;
                end else if (shutdown_cyc) begin
                    state_d = ST_SD_REQ;
                end
            end
            ST_HARD: begin
                if (tmr_zero) begin
                    state_d = ST_RUN;
                end
            end
            ST_SD_REQ: begin
                if (sd_ack) begin
                    tmr_load = 1'b1;
                    tmr_val  = INIT_LD;
                    state_d  = ST_INIT;
                end
            end
            ST_INIT: begin
                if (tmr_zero) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_POR_WAIT;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cpu_rst   = 1'b0;
        pci_rst   = 1'b0;
        addr_hold = 1'b0;
        cpu_init  = 1'b0;
        sd_req    = 1'b0;
        unique case (state_q)
            ST_POR_WAIT, ST_POR_DONE: begin
                cpu_rst   = 1'b1;
                pci_rst   = 1'b1;
                addr_hold = 1'b1;
            end
            ST_HARD: begin
                cpu_rst = 1'b1;
                pci_rst = 1'b1;
            end
            ST_SD_REQ: sd_req   = 1'b1;
            ST_INIT:   cpu_init = 1'b1;
            ST_RUN:    ;
            default:   ;
        endcase
    end

    // Assertions
    p_rst_pair_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        cpu_rst == pci_rst);

    p_hard_nohold_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(cpu_rst) |-> !addr_hold);

    p_release_r5: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(addr_hold) |-> (!cpu_rst && !pci_rst));

    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        !strap_en |=> $stable(strap_q));

    p_init_excl_r8: assert property (@(posedge clk) disable iff (!pwr_good)
        cpu_init |-> (!cpu_rst && !sd_req && !addr_hold));

    p_init_min_r8: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(cpu_init) |=> cpu_init);

    p_sd_wait_r10: assert property (@(posedge clk) disable iff (!pwr_good)
        (sd_req && !sd_ack) |=> (sd_req && !cpu_init));

    p_sd_init_r10: assert property (@(posedge clk) disable iff (!pwr_good)
        (sd_req && sd_ack) |=> (cpu_init && !sd_req));

endmodule

// File: tb/rst_strap_seq_bench.sv
module rst_strap_seq_bench;

    localparam int KHZ   = 20;
    localparam int HOLD  = KHZ;
    localparam int INITN = 2;
    localparam logic [15:0] CTRL = 16'h0CF9;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b1;
    logic [2:0]  host_addr_hi = 3'b000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        shutdown_cyc = 1'b0;
    logic        sd_ack = 1'b0;
    logic        sd_req, cpu_rst, pci_rst, addr_hold, cpu_init, sram_type;
    logic [1:0]  cache_size;

    int    vectors = 0;
    int    fails = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    rst_strap_seq #(
        .CLK_KHZ  (KHZ),
        .HOLD_MS  (1),
        .INIT_CYC (INITN)
    ) u_rst_strap_seq (
        .clk          (clk),
        .pwr_good     (pwr_good),
        .host_addr_hi (host_addr_hi),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_rdata     (io_rdata),
        .shutdown_cyc (shutdown_cyc),
        .sd_ack       (sd_ack),
        .sd_req       (sd_req),
        .cpu_rst      (cpu_rst),
        .pci_rst      (pci_rst),
        .addr_hold    (addr_hold),
        .cpu_init     (cpu_init),
        .cache_size   (cache_size),
        .sram_type    (sram_type)
    );

    // Reference model state
    int         m_edges = 0;
    int         m_hard  = 0;
    int         m_init  = 0;
    bit         m_sd    = 1'b0;
    logic [7:0] m_ctrl  = 8'h00;
    logic [1:0] m_cs    = 2'b00;
    bit         m_st    = 1'b0;

    always @(negedge pwr_good) begin
        m_edges = 0; m_hard = 0; m_init = 0; m_sd = 1'b0;
        m_ctrl = 8'h00; m_cs = 2'b00; m_st = 1'b0;
    end

    always @(posedge clk) begin
        if (pwr_good) begin
            bit busy;
            bit taken;
            busy  = (m_edges <= HOLD) || (m_hard > 0) || (m_init > 0) || m_sd;
            taken = 1'b0;
            m_edges++;
            if (m_edges == HOLD) begin
                case (host_addr_hi[2:1])
                    2'b11: m_cs = 2'b00;
                    2'b10: m_cs = 2'b01;
                    2'b01: m_cs = 2'b10;
                    default: m_cs = 2'b11;
                endcase
                m_st = !host_addr_hi[0];
            end
            if (m_hard > 0) m_hard--;
            if (m_init > 0) m_init--;
            if (m_sd && sd_ack) begin
                m_sd = 1'b0;
                m_init = INITN;
            end
            if (io_wr && io_addr == CTRL) begin
                if (!busy && io_wdata[2] && !m_ctrl[2]) begin
                    taken = 1'b1;
                    if (io_wdata[1]) m_hard = HOLD;
                    else             m_init = INITN;
                end
                m_ctrl = io_wdata;
            end
            if (!busy && !taken && shutdown_cyc) m_sd = 1'b1;
        end
    end

    task automatic cmp1(string name, logic [7:0] act, logic [7:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_tag, name, act, exp, $time);
            bad = 1'b1;
        end
    endtask

    always @(negedge clk) begin
        bit por;
        bit bad;
        logic [7:0] exp_rd;
        por = !pwr_good || (m_edges <= HOLD);
        exp_rd = (io_rd && io_addr == CTRL) ? m_ctrl : 8'h00;
        bad = 1'b0;
        vectors++;
        cmp1("cpu_rst",    {7'b0, cpu_rst},   {7'b0, por || (m_hard > 0)}, bad);
        cmp1("pci_rst",    {7'b0, pci_rst},   {7'b0, por || (m_hard > 0)}, bad);
        cmp1("addr_hold",  {7'b0, addr_hold}, {7'b0, por}, bad);
        cmp1("cpu_init",   {7'b0, cpu_init},  {7'b0, pwr_good && (m_init > 0)}, bad);
        cmp1("sd_req",     {7'b0, sd_req},    {7'b0, pwr_good && m_sd}, bad);
        cmp1("cache_size", {6'b0, cache_size}, {6'b0, m_cs}, bad);
        cmp1("sram_type",  {7'b0, sram_type}, {7'b0, m_st}, bad);
        cmp1("io_rdata",   io_rdata, exp_rd, bad);
        if (bad) fails++;
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step(1);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a);
        io_addr = a; io_rd = 1'b1;
        step(1);
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        finish_run();
    end

    initial begin
        #0 pwr_good = 1'b0;
        cur_tag = "R1";
        step(4);
        // R3 / R4: every strap combination held steady through start-up
        for (int p = 0; p < 8; p++) begin
            cur_tag = (p % 2 == 0) ? "R3" : "R4";
            host_addr_hi = 3'(p);
            pwr_good = 1'b1;
            step(HOLD - 1);
            cur_tag = "R5";
            step(4);
            cur_tag = "R1";
            pwr_good = 1'b0;
            step(2);
        end
        // R2: address changes each cycle; R11: write during start-up is stored only
        cur_tag = "R2";
        pwr_good = 1'b1;
        for (int i = 0; i < HOLD + 4; i++) begin
            host_addr_hi = 3'($urandom);
            if (i == 3) begin
                cur_tag = "R11";
                io_addr = CTRL; io_wdata = 8'h06; io_wr = 1'b1;
            end
            step(1);
            io_wr = 1'b0;
            if (i == 3) cur_tag = "R2";
        end
        cur_tag = "R11";
        rd(CTRL);
        // R6: register access
        cur_tag = "R6";
        wr(CTRL, 8'h81);
        rd(CTRL);
        wr(16'h0CF8, 8'hFF);
        rd(CTRL);
        rd(16'h0CF8);
        // R8: soft reset
        cur_tag = "R8";
        wr(CTRL, 8'h04);
        step(5);
        // R9: no rising edge
        cur_tag = "R9";
        wr(CTRL, 8'h04);
        step(3);
        wr(CTRL, 8'h06);
        step(3);
        wr(CTRL, 8'h00);
        step(2);
        // R7: hard reset, with R11 requests during it
        cur_tag = "R7";
        wr(CTRL, 8'h06);
        cur_tag = "R11";
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h04);
        shutdown_cyc = 1'b1;
        step(1);
        shutdown_cyc = 1'b0;
        cur_tag = "R7";
        step(HOLD + 2);
        rd(CTRL);
        // R10: shutdown handshake, delayed acknowledge
        cur_tag = "R10";
        wr(CTRL, 8'h00);
        shutdown_cyc = 1'b1;
        step(1);
        shutdown_cyc = 1'b0;
        step(3);
        sd_ack = 1'b1;
        step(1);
        sd_ack = 1'b0;
        step(4);
        // R10: immediate acknowledge
        shutdown_cyc = 1'b1; sd_ack = 1'b1;
        step(1);
        shutdown_cyc = 1'b0;
        step(1);
        sd_ack = 1'b0;
        step(4);
        // R12: restart write and shutdown on the same edge
        cur_tag = "R12";
        io_addr = CTRL; io_wdata = 8'h04; io_wr = 1'b1; shutdown_cyc = 1'b1;
        step(1);
        io_wr = 1'b0; shutdown_cyc = 1'b0;
        step(5);
        // R1: power loss mid-run clears everything
        cur_tag = "R1";
        pwr_good = 1'b0;
        io_addr = CTRL; io_rd = 1'b1;
        step(3);
        io_rd = 1'b0;
        step(1);
        finish_run();
    end

endmodule